// File: doc/BRIEF.md
# Keyboard and Auxiliary Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the host side of a legacy keyboard controller. Each source raises a level flag while it holds a byte for the host. The arbiter turns those two flags into the output-buffer-full indications seen in the status register and mirrored on the controller's output port. It also produces the two interrupt request levels, the keyboard line and the auxiliary line, and these are gated by three bits of the controller's mode byte.

On a host read of the data port, the arbiter decides which source supplies the byte. It captures that byte and sends a single pop pulse to the chosen source. The keyboard always wins. The auxiliary channel is shown as the owner of the buffer only when it alone holds data.

The core is a four-state machine whose state is the registered pending mask. Its states are `OB_EMPTY` (nothing pending), `OB_KBD` (keyboard only), `OB_AUX` (auxiliary only) and `OB_BOTH` (both pending). From any state, the next clock edge moves the machine to the state named by the two flags sampled at that edge. The transitions are named after their targets: `GO_EMPTY`, `GO_KBD`, `GO_AUX` and `GO_BOTH`.

Top module: `ob_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all flag, interrupt, select and pop outputs are 0 and `rd_data` is 0.
- R2: `stat_obf` and `port_obf` are 1 in the cycle after a clock edge that sampled `pend` (bit 0 = keyboard, bit 1 = auxiliary) as non-zero, and 0 after an edge that sampled it as 00.
- R3: `stat_aux_obf` and `port_aux_obf` are 1 only after an edge that sampled `pend` = 10. With `pend` = 11 they are 0.
- R4: `irq_kbd` is a registered level. It is 1 after an edge that sampled `pend[0]`=1, `kbd_irq_en`=1 and `kbd_off`=0, and 0 otherwise.
- R5: `irq_aux` is a registered level. It is 1 after an edge that sampled `pend` = 10 and `aux_irq_en`=1, and 0 otherwise.
- R6: `rd_sel_aux` is 1 exactly when the registered mask is 10. Otherwise the keyboard is selected, which includes the case where both sources are pending.
- R7: A `rd_strobe` cycle with a non-zero registered mask produces, after the next edge, a one-cycle pulse on `pop_aux` (mask 10) or `pop_kbd` (mask 01 or 11), never on both. In the same step `rd_data` takes the byte of that source.
- R8: A `rd_strobe` cycle with registered mask 00 pops nothing and leaves `rd_data` holding the last byte read.
- R9: A change on a mode input alone, with `pend` held steady, updates the interrupt outputs after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | 2 | Pending flags: bit 0 keyboard, bit 1 auxiliary |
| kbd_irq_en | input | 1 | Mode: keyboard interrupt enable |
| aux_irq_en | input | 1 | Mode: auxiliary interrupt enable |
| kbd_off | input | 1 | Mode: keyboard interface disabled |
| rd_strobe | input | 1 | Host data-port read, one cycle |
| kbd_byte | input | DATA_W | Head byte of the keyboard source |
| aux_byte | input | DATA_W | Head byte of the auxiliary source |
| stat_obf | output | 1 | Status: output buffer full |
| stat_aux_obf | output | 1 | Status: buffer holds auxiliary data |
| port_obf | output | 1 | Output port mirror, bit 4 |
| port_aux_obf | output | 1 | Output port mirror, bit 5 |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| rd_sel_aux | output | 1 | Read source select: 1 = auxiliary |
| pop_kbd | output | 1 | Pop pulse to keyboard source |
| pop_aux | output | 1 | Pop pulse to auxiliary source |
| rd_data | output | DATA_W | Last byte read by the host |

## Verification
A host read and a change of the pending flags can land on the same clock edge. In that case the pop is decided by the mask registered before the edge, while the flags and interrupts take the new mask. The bench provokes this by raising a read strobe in the step where `pend` goes from 10 to 11. It judges the result by checking two things: that the auxiliary byte and an auxiliary pop appear, and that in the same cycle the status has already fallen back to keyboard ownership. A similar step reads during a change from 01 to 00 and expects the keyboard pop with an empty buffer.

// File: rtl/ob_arb_pkg.sv
package ob_arb_pkg;
    // State code equals the pending mask: bit 0 keyboard, bit 1 auxiliary.
    typedef enum logic [1:0] {
        OB_EMPTY = 2'b00,
        OB_KBD   = 2'b01,
        OB_AUX   = 2'b10,
        OB_BOTH  = 2'b11
    } ob_state_e;

    localparam int unsigned SRC_N = 2;
endpackage

// File: rtl/ob_pend_fsm.sv
module ob_pend_fsm
    import ob_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     pend,
    output ob_state_e            state_q,
    output logic                 obf,
    output logic                 aux_flag,
    output logic                 sel_aux
);
    ob_state_e state_d;

    // Transitions GO_EMPTY / GO_KBD / GO_AUX / GO_BOTH, taken from any state.
    always_comb begin
        unique case (pend)
            2'b00:   state_d = OB_EMPTY;
            2'b01:   state_d = OB_KBD;
            2'b10:   state_d = OB_AUX;
            default: state_d = OB_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        obf      = 1'b0;
        aux_flag = 1'b0;
        sel_aux  = 1'b0;
        unique case (state_q)
            OB_EMPTY: ;
            OB_KBD:   obf = 1'b1;
            OB_AUX: begin
                obf      = 1'b1;
                aux_flag = 1'b1;
                sel_aux  = 1'b1;
            end
            OB_BOTH:  obf = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ob_irq_gen.sv
module ob_irq_gen
    import ob_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pend,
    input  logic             kbd_irq_en,
    input  logic             aux_irq_en,
    input  logic             kbd_off,
    output logic             irq_kbd,
    output logic             irq_aux
);
    logic kbd_lvl;
    logic aux_lvl;

    always_comb begin
        kbd_lvl = 1'b0;
        aux_lvl = 1'b0;
        unique case (ob_state_e'(pend))
            OB_EMPTY: ;
            OB_AUX:   aux_lvl = aux_irq_en;
            OB_KBD,
            OB_BOTH:  kbd_lvl = kbd_irq_en & ~kbd_off;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_kbd <= 1'b0;
            irq_aux <= 1'b0;
        end else begin
            irq_kbd <= kbd_lvl;
            irq_aux <= aux_lvl;
        end
    end
endmodule

// File: rtl/ob_read_port.sv
module ob_read_port
    import ob_arb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  ob_state_e         state_q,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic [DATA_W-1:0] aux_byte,
    output logic              pop_kbd,
    output logic              pop_aux,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_kbd <= 1'b0;
            pop_aux <= 1'b0;
            rd_data <= '0;
        end else begin
            pop_kbd <= 1'b0;
            pop_aux <= 1'b0;
            if (rd_strobe) begin
                unique case (state_q)
                    OB_EMPTY: ;
                    OB_AUX: begin
                        pop_aux <= 1'b1;
                        rd_data <= aux_byte;
                    end
                    OB_KBD,
                    OB_BOTH: begin
                        pop_kbd <= 1'b1;
                        rd_data <= kbd_byte;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ob_arbiter.sv
module ob_arbiter
    import ob_arb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pend,
    input  logic              kbd_irq_en,
    input  logic              aux_irq_en,
    input  logic              kbd_off,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic [DATA_W-1:0] aux_byte,
    output logic              stat_obf,
    output logic              stat_aux_obf,
    output logic              port_obf,
    output logic              port_aux_obf,
    output logic              irq_kbd,
    output logic              irq_aux,
    output logic              rd_sel_aux,
    output logic              pop_kbd,
    output logic              pop_aux,
    output logic [DATA_W-1:0] rd_data
);
    ob_state_e state_q;
    logic      obf;
    logic      aux_flag;

    ob_pend_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .state_q  (state_q),
        .obf      (obf),
        .aux_flag (aux_flag),
        .sel_aux  (rd_sel_aux)
    );

    ob_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .kbd_irq_en (kbd_irq_en),
        .aux_irq_en (aux_irq_en),
        .kbd_off    (kbd_off),
        .irq_kbd    (irq_kbd),
        .irq_aux    (irq_aux)
    );

    ob_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .state_q   (state_q),
        .kbd_byte  (kbd_byte),
        .aux_byte  (aux_byte),
        .pop_kbd   (pop_kbd),
        .pop_aux   (pop_aux),
        .rd_data   (rd_data)
    );

    assign stat_obf     = obf;
    assign port_obf     = obf;
    assign stat_aux_obf = aux_flag;
    assign port_aux_obf = aux_flag;
endmodule

// File: rtl/ob_arbiter_chk.sv
module ob_arbiter_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pend,
    input logic              kbd_irq_en,
    input logic              aux_irq_en,
    input logic              kbd_off,
    input logic              rd_strobe,
    input logic              stat_obf,
    input logic              stat_aux_obf,
    input logic              irq_kbd,
    input logic              irq_aux,
    input logic              rd_sel_aux,
    input logic              pop_kbd,
    input logic              pop_aux,
    input logic [DATA_W-1:0] rd_data
);
    AST_AUX_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_aux_obf |-> stat_obf); // R3
    AST_FULL_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != 2'b00) |=> stat_obf); // R2
    AST_IRQ_KBD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_off || !kbd_irq_en) |=> !irq_kbd); // R4
    AST_IRQ_AUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != 2'b10 || !aux_irq_en) |=> !irq_aux); // R5
    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_kbd, pop_aux})); // R7
    AST_POP_AUX_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_sel_aux) |=> pop_aux); // R6
    AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_kbd || pop_aux) |-> $past(rd_strobe)); // R7
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !stat_obf) |=> (!pop_kbd && !pop_aux && $stable(rd_data))); // R8
endmodule

bind ob_arbiter ob_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend         (pend),
    .kbd_irq_en   (kbd_irq_en),
    .aux_irq_en   (aux_irq_en),
    .kbd_off      (kbd_off),
    .rd_strobe    (rd_strobe),
    .stat_obf     (stat_obf),
    .stat_aux_obf (stat_aux_obf),
    .irq_kbd      (irq_kbd),
    .irq_aux      (irq_aux),
    .rd_sel_aux   (rd_sel_aux),
    .pop_kbd      (pop_kbd),
    .pop_aux      (pop_aux),
    .rd_data      (rd_data)
);

// File: tb/ob_arbiter_test.sv
module ob_arbiter_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pend = 2'b00;
    logic          kbd_irq_en = 1'b0, aux_irq_en = 1'b0, kbd_off = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [DW-1:0] kbd_byte = '0, aux_byte = '0;
    logic          stat_obf, stat_aux_obf, port_obf, port_aux_obf;
    logic          irq_kbd, irq_aux, rd_sel_aux, pop_kbd, pop_aux;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic          obf, aobf, ik, ia, sel, pk, pa;
        logic [DW-1:0] data;
    } exp_t;
    exp_t q[$];

    logic [1:0]    m_mask = 2'b00;
    logic [DW-1:0] m_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    ob_arbiter #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .kbd_irq_en(kbd_irq_en), .aux_irq_en(aux_irq_en), .kbd_off(kbd_off),
        .rd_strobe(rd_strobe), .kbd_byte(kbd_byte), .aux_byte(aux_byte),
        .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
        .port_obf(port_obf), .port_aux_obf(port_aux_obf),
        .irq_kbd(irq_kbd), .irq_aux(irq_aux), .rd_sel_aux(rd_sel_aux),
        .pop_kbd(pop_kbd), .pop_aux(pop_aux), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result of its edge.
    task automatic step(input logic [1:0] p, input logic ke, input logic ae, input logic ko,
                        input logic rs, input logic [DW-1:0] kb, input logic [DW-1:0] ab);
        exp_t e;
        @(negedge clk);
        pend = p; kbd_irq_en = ke; aux_irq_en = ae; kbd_off = ko;
        rd_strobe = rs; kbd_byte = kb; aux_byte = ab;
        e.pk = 1'b0; e.pa = 1'b0;
        if (rs && m_mask != 2'b00) begin
            if (m_mask == 2'b10) begin e.pa = 1'b1; m_data = ab; end
            else begin e.pk = 1'b1; m_data = kb; end
        end
        e.data = m_data;
        m_mask = p;
        e.obf  = (p != 2'b00);
        e.aobf = (p == 2'b10);
        e.sel  = (p == 2'b10);
        e.ik   = p[0] & ke & ~ko;
        e.ia   = (p == 2'b10) & ae;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge, away from the edges.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R2", "stat_obf",     {7'd0, stat_obf},     {7'd0, e.obf});
                chk("R2", "port_obf",     {7'd0, port_obf},     {7'd0, e.obf});
                chk("R3", "stat_aux_obf", {7'd0, stat_aux_obf}, {7'd0, e.aobf});
                chk("R3", "port_aux_obf", {7'd0, port_aux_obf}, {7'd0, e.aobf});
                chk("R4", "irq_kbd",      {7'd0, irq_kbd},      {7'd0, e.ik});
                chk("R5", "irq_aux",      {7'd0, irq_aux},      {7'd0, e.ia});
                chk("R6", "rd_sel_aux",   {7'd0, rd_sel_aux},   {7'd0, e.sel});
                chk("R7", "pop_kbd",      {7'd0, pop_kbd},      {7'd0, e.pk});
                chk("R7", "pop_aux",      {7'd0, pop_aux},      {7'd0, e.pa});
                chk("R8", "rd_data",      rd_data,              e.data);
            end
        end
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "obf",  {7'd0, stat_obf}, 8'd0);
        chk("R1", "irqs", {6'd0, irq_kbd, irq_aux}, 8'd0);
        chk("R1", "pops", {6'd0, pop_kbd, pop_aux}, 8'd0);
        chk("R1", "data", rd_data, 8'd0);
        rst_n = 1'b1;
        step(2'b00, 1, 1, 0, 0, 8'h11, 8'h22);   // R1 idle after reset
        step(2'b01, 1, 1, 0, 0, 8'h11, 8'h22);   // R2 R4 keyboard pending
        step(2'b01, 1, 1, 1, 0, 8'h11, 8'h22);   // R9 keyboard disabled
        step(2'b01, 0, 1, 0, 0, 8'h11, 8'h22);   // R9 keyboard irq off
        step(2'b01, 1, 1, 0, 0, 8'h11, 8'h22);   // R9 back on
        step(2'b10, 1, 1, 0, 0, 8'h11, 8'h22);   // R3 R5 R6 aux only
        step(2'b10, 1, 0, 0, 0, 8'h11, 8'h22);   // R9 aux irq off
        step(2'b10, 1, 1, 0, 1, 8'h11, 8'h5a);   // R7 aux read
        step(2'b11, 1, 1, 0, 0, 8'h11, 8'h22);   // R3 R6 both: keyboard wins
        step(2'b11, 1, 1, 0, 1, 8'hc3, 8'h22);   // R7 read with both pending
        step(2'b00, 1, 1, 0, 0, 8'h11, 8'h22);   // R2 empty
        step(2'b00, 1, 1, 0, 1, 8'h77, 8'h88);   // R8 empty read holds data
        step(2'b10, 1, 1, 0, 0, 8'h11, 8'h22);
        step(2'b11, 1, 1, 0, 1, 8'h33, 8'h44);   // R7 read while flags change
        step(2'b01, 1, 1, 0, 0, 8'h11, 8'h22);
        step(2'b00, 1, 1, 0, 1, 8'h66, 8'h99);   // R7 keyboard read as it empties
        step(2'b00, 1, 1, 0, 0, 8'h11, 8'h22);   // R7 pop lasts one cycle
        step(2'b00, 0, 0, 0, 1, 8'h12, 8'h34);   // R8 again
        step(2'b00, 0, 0, 0, 0, 8'h12, 8'h34);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule